// File: doc/BRIEF.md
# Twin-Structure Shift-Register Random Source

This block holds two independent linear-feedback shift registers: one built in the external-XOR (Fibonacci) form and one in the internal-XOR (Galois) form. Each register has its own control lane with a seed input, a load strobe, a step strobe and a shift-direction select, and shows its present contents on a state output. Register width, tap mask and reset value are parameters for each lane. With the defaults, the Fibonacci lane is 32 bits wide with taps at bits 0, 2, 3, 5 and 10, and the Galois lane is 16 bits wide with taps at bits 1 and 2.

A lane is used by loading a seed and then pulsing the step strobe once for each new pseudo-random value. The direction input is sampled on every step, so successive steps may shift in different directions. Each lane decodes a per-cycle operation from its strobes. The operations are HOLD (no strobe), LOAD (load strobe high, whatever the step strobe is) and STEP (step strobe high, load strobe low). The register takes the reset value while reset is asserted.

Top module: `dual_lfsr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, each state output shows its lane's nonzero reset value: 32'h0000_0001 for the Fibonacci lane and 16'hACE1 for the Galois lane.
- R2: A cycle with the load strobe high writes the seed input into the register. The seed appears on the state output after that clock edge.
- R3: A cycle with the step strobe high advances the register by exactly one step. A cycle with both strobes low leaves the state output unchanged.
- R4: When the load strobe and the step strobe are high in the same cycle, the seed is loaded and no step is taken.
- R5: Fibonacci, direction 0 (left): every bit moves up one position, and bit 0 receives the XOR of the bits selected by the tap mask before the shift.
- R6: Fibonacci, direction 1 (right): every bit moves down one position, and the MSB receives the XOR of the tapped bits before the shift.
- R7: Galois, direction 0 (left): the MSB is shifted out and written into bit 0. The same bit is XORed into every tapped position of the shifted word.
- R8: Galois, direction 1 (right): bit 0 is shifted out and written into the MSB. The same bit is XORed into every tapped position of the shifted word.
- R9: The direction input is applied to each step on its own, so alternating directions from one step to the next gives the mix of the two step rules.
- R10: The two lanes are independent. Strobes on one lane never change the other lane's state output.
- R11: An all-zero seed is loaded as given, and the register then stays at zero through any number of steps in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fib_seed | input | FIB_W | Seed value for the Fibonacci lane |
| fib_load | input | 1 | Load strobe for the Fibonacci lane |
| fib_step | input | 1 | Step strobe for the Fibonacci lane |
| fib_dir | input | 1 | Fibonacci shift direction (0 left, 1 right) |
| fib_state | output | FIB_W | Fibonacci register contents |
| gal_seed | input | GAL_W | Seed value for the Galois lane |
| gal_load | input | 1 | Load strobe for the Galois lane |
| gal_step | input | 1 | Step strobe for the Galois lane |
| gal_dir | input | 1 | Galois shift direction (0 left, 1 right) |
| gal_state | output | GAL_W | Galois register contents |

## Verification
The two functions that can fall in the same cycle are seed loading and stepping. The bench raises both strobes together on each lane while the register holds a value that a step would change. The expected result is the seed with no step applied, so a design that steps after loading, or steps instead of loading, differs at the output. The bench also changes the direction input in the same cycle as a step on every cycle of a run, and compares the result against a model that applies each step's own direction.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } lane_op_e;

endpackage

// File: rtl/lfsr_fib_next.sv
module lfsr_fib_next #(
    parameter int            W    = 32,
    parameter logic [W-1:0]  TAPS = 32'h0000_042D
) (
    input  logic [W-1:0]        cur,
    input  lfsr_pkg::shift_dir_e dir,
    output logic [W-1:0]        nxt
);
    import lfsr_pkg::*;

    logic feedback;

    assign feedback = ^(cur & TAPS);

    always_comb begin
        unique case (dir)
            SHIFT_LEFT:  nxt = {cur[W-2:0], feedback};
            SHIFT_RIGHT: nxt = {feedback, cur[W-1:1]};
            default:     nxt = cur;
        endcase
    end
endmodule

// File: rtl/lfsr_gal_next.sv
module lfsr_gal_next #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  TAPS = 16'h0006
) (
    input  logic [W-1:0]        cur,
    input  lfsr_pkg::shift_dir_e dir,
    output logic [W-1:0]        nxt
);
    import lfsr_pkg::*;

    logic         out_bit;
    logic [W-1:0] rotated;

    always_comb begin
        unique case (dir)
            SHIFT_LEFT: begin
                out_bit = cur[W-1];
                rotated = {cur[W-2:0], cur[W-1]};
            end
            SHIFT_RIGHT: begin
                out_bit = cur[0];
                rotated = {cur[0], cur[W-1:1]};
            end
            default: begin
                out_bit = 1'b0;
                rotated = cur;
            end
        endcase
        nxt = rotated ^ (TAPS & {W{out_bit}});
    end
endmodule

// File: rtl/lfsr_lane.sv
module lfsr_lane #(
    parameter int            W       = 32,
    parameter logic [W-1:0]  TAPS    = '0,
    parameter logic [W-1:0]  RST_VAL = 1,
    parameter bit            GALOIS  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         load,
    input  logic         step,
    input  logic         dir,
    output logic [W-1:0] state
);
    import lfsr_pkg::*;

    lane_op_e     op;
    shift_dir_e   dir_e;
    logic [W-1:0] state_q;
    logic [W-1:0] stepped;

    assign dir_e = shift_dir_e'(dir);

    // Operation decode: load wins over step.
    always_comb begin
        if (load)      op = OP_LOAD;
        else if (step) op = OP_STEP;
        else           op = OP_HOLD;
    end

    generate
        if (GALOIS) begin : g_gal
            lfsr_gal_next #(.W(W), .TAPS(TAPS)) u_next (
                .cur(state_q), .dir(dir_e), .nxt(stepped));
        end else begin : g_fib
            lfsr_fib_next #(.W(W), .TAPS(TAPS)) u_next (
                .cur(state_q), .dir(dir_e), .nxt(stepped));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_VAL;
        end else begin
            unique case (op)
                OP_LOAD: state_q <= seed;
                OP_STEP: state_q <= stepped;
                OP_HOLD: state_q <= state_q;
                default: state_q <= state_q;
            endcase
        end
    end

    always_comb state = state_q;

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state == RST_VAL);
    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == $past(seed));
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(state));
    // R11
    zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && state == '0) |=> state == '0);

    generate
        if (GALOIS) begin : g_gal_chk
            // R7
            gal_left_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_STEP && dir_e == SHIFT_LEFT) |=>
                    state[0] == ($past(state[W-1]) ^ ($past(state[W-1]) & TAPS[0])));
            // R8
            gal_right_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_STEP && dir_e == SHIFT_RIGHT) |=>
                    state[W-1] == ($past(state[0]) ^ ($past(state[0]) & TAPS[W-1])));
        end else begin : g_fib_chk
            // R5
            fib_left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_STEP && dir_e == SHIFT_LEFT) |=>
                    state[W-1:1] == $past(state[W-2:0]));
            // R6
            fib_right_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_STEP && dir_e == SHIFT_RIGHT) |=>
                    state[W-2:0] == $past(state[W-1:1]));
        end
    endgenerate
endmodule

// File: rtl/dual_lfsr_gen.sv
module dual_lfsr_gen #(
    parameter int                FIB_W    = 32,
    parameter logic [FIB_W-1:0]  FIB_TAPS = 32'h0000_042D,
    parameter logic [FIB_W-1:0]  FIB_RST  = 32'h0000_0001,
    parameter int                GAL_W    = 16,
    parameter logic [GAL_W-1:0]  GAL_TAPS = 16'h0006,
    parameter logic [GAL_W-1:0]  GAL_RST  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FIB_W-1:0] fib_seed,
    input  logic             fib_load,
    input  logic             fib_step,
    input  logic             fib_dir,
    output logic [FIB_W-1:0] fib_state,
    input  logic [GAL_W-1:0] gal_seed,
    input  logic             gal_load,
    input  logic             gal_step,
    input  logic             gal_dir,
    output logic [GAL_W-1:0] gal_state
);

    lfsr_lane #(.W(FIB_W), .TAPS(FIB_TAPS), .RST_VAL(FIB_RST), .GALOIS(1'b0)) u_fib (
        .clk(clk), .rst_n(rst_n), .seed(fib_seed), .load(fib_load),
        .step(fib_step), .dir(fib_dir), .state(fib_state));

    lfsr_lane #(.W(GAL_W), .TAPS(GAL_TAPS), .RST_VAL(GAL_RST), .GALOIS(1'b1)) u_gal (
        .clk(clk), .rst_n(rst_n), .seed(gal_seed), .load(gal_load),
        .step(gal_step), .dir(gal_dir), .state(gal_state));

    // R10
    lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gal_load && !gal_step && (fib_load || fib_step)) |=> $stable(gal_state));
endmodule

// File: tb/tb_dual_lfsr_gen.sv
module tb_dual_lfsr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fib_seed = '0;
    logic        fib_load = 1'b0, fib_step = 1'b0, fib_dir = 1'b0;
    logic [31:0] fib_state;
    logic [15:0] gal_seed = '0;
    logic        gal_load = 1'b0, gal_step = 1'b0, gal_dir = 1'b0;
    logic [15:0] gal_state;

    always #4 clk = ~clk;

    dual_lfsr_gen dut (
        .clk(clk), .rst_n(rst_n),
        .fib_seed(fib_seed), .fib_load(fib_load), .fib_step(fib_step),
        .fib_dir(fib_dir), .fib_state(fib_state),
        .gal_seed(gal_seed), .gal_load(gal_load), .gal_step(gal_step),
        .gal_dir(gal_dir), .gal_state(gal_state));

    typedef struct {
        logic [31:0] f;
        logic [15:0] g;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] mf;
    logic [15:0] mg;

    function automatic logic [31:0] fib_model(logic [31:0] s, logic d);
        int          tp[5] = '{0, 2, 3, 5, 10};
        logic        x = 1'b0;
        logic [31:0] n;
        foreach (tp[i]) x = x ^ s[tp[i]];
        if (d == 1'b0) begin
            for (int b = 31; b > 0; b--) n[b] = s[b-1];
            n[0] = x;
        end else begin
            for (int b = 0; b < 31; b++) n[b] = s[b+1];
            n[31] = x;
        end
        return n;
    endfunction

    function automatic logic [15:0] gal_model(logic [15:0] s, logic d);
        int          tp[2] = '{1, 2};
        logic        o;
        logic [15:0] n;
        if (d == 1'b0) begin
            o = s[15];
            n = s << 1;
            n[0] = o;
        end else begin
            o = s[0];
            n = s >> 1;
            n[15] = o;
        end
        foreach (tp[i]) n[tp[i]] = n[tp[i]] ^ o;
        return n;
    endfunction

    task automatic check(string tag, logic [31:0] af, logic [31:0] ef);
        total++;
        if (af !== ef) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, af, ef);
        end
    endtask

    // Driver: one cycle of stimulus on both lanes, expected result queued.
    task automatic cyc(logic fl, logic fs, logic fd, logic [31:0] fsd,
                       logic gl, logic gs, logic gd, logic [15:0] gsd, string tag);
        @(negedge clk);
        fib_load = fl; fib_step = fs; fib_dir = fd; fib_seed = fsd;
        gal_load = gl; gal_step = gs; gal_dir = gd; gal_seed = gsd;
        if (fl)      mf = fsd;
        else if (fs) mf = fib_model(mf, fd);
        if (gl)      mg = gsd;
        else if (gs) mg = gal_model(mg, gd);
        sb.push_back('{mf, mg, tag});
    endtask

    // Monitor: compares one queued item per clock, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check({it.tag, " fib"}, fib_state, it.f);
                check({it.tag, " gal"}, {16'h0, gal_state}, {16'h0, it.g});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        mf = 32'h0000_0001;
        mg = 16'hACE1;
        #20;
        check("R1 reset fib", fib_state, 32'h0000_0001);
        check("R1 reset gal", {16'h0, gal_state}, 32'h0000_ACE1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release fib", fib_state, 32'h0000_0001);
        check("R1 after release gal", {16'h0, gal_state}, 32'h0000_ACE1);

        // R2 seed load on both lanes
        cyc(1, 0, 0, 32'hDEAD_BEEF, 1, 0, 1, 16'h1234, "R2 load");
        // R5 and R8: Fibonacci left, Galois right
        for (int i = 0; i < 12; i++) cyc(0, 1, 0, '0, 0, 1, 1, '0, "R5 R8 step");
        // R3 hold with both strobes low
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 16'hFFFF, "R3 hold");
        // R6 and R7: Fibonacci right, Galois left
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, '0, 0, 1, 0, '0, "R6 R7 step");
        // R4 load and step together
        cyc(1, 1, 0, 32'h8000_0421, 1, 1, 1, 16'h8001, "R4 load wins");
        cyc(1, 1, 1, 32'h0F0F_0F0F, 1, 1, 0, 16'hF00F, "R4 load wins again");
        // R9 direction flips each step
        for (int i = 0; i < 10; i++) cyc(0, 1, i[0], '0, 0, 1, ~i[0], '0, "R9 alternate");
        // R10 one lane active while the other is idle
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, '0, 0, 0, 1, 16'h5555, "R10 fib only");
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 32'h5555_5555, 0, 1, 0, '0, "R10 gal only");
        cyc(1, 0, 0, 32'h1357_9BDF, 0, 0, 0, 16'h0, "R10 fib load only");
        // R11 zero seed locks
        cyc(1, 0, 0, 32'h0, 1, 0, 0, 16'h0, "R11 zero load");
        for (int i = 0; i < 6; i++) cyc(0, 1, i[1], '0, 0, 1, i[0], '0, "R11 zero stays");
        // R2 reload after lock-up
        cyc(1, 0, 0, 32'h0000_0400, 1, 0, 0, 16'h0004, "R2 reload");
        cyc(0, 1, 0, '0, 0, 1, 0, '0, "R5 R7 after reload");
        cyc(0, 0, 0, '0, 0, 0, 0, '0, "R3 idle");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule